// File: doc/BRIEF.md
# Dual-Path Branch Target Prefetcher

This block is the instruction-fetch front end of a pipelined core. It holds two small prefetch queues. One queue feeds the decoder with the fall-through (sequential) stream. When decode reports a conditional branch together with its target address, the second queue begins to collect instructions from that target. The target reads go only into memory cycles that the sequential stream does not use. The block does not predict the branch outcome. It keeps both paths warm until the execute stage reports how the branch went.

On a not-taken outcome the target queue is dropped, and the sequential instructions already queued keep flowing with no gap. On a taken outcome the sequential queue is flushed and the two queues swap roles. The decoder then receives the prefetched target instructions at once, and sequential fetching continues after the last target word that was already read. Only one branch can be outstanding at a time. A second branch is held off through a ready signal until the first one resolves.

Memory is a single read port. A request carries a word address, data returns combinationally in the cycle the request is granted, and the memory may withhold the grant. Each instruction leaves the block on a valid/ready handshake together with its word address.

Top module: `dual_path_prefetch`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0, `br_ready` is 1, and a memory request is presented at address `RESET_PC` (default 0x0100).
- R2: With no taken branch, instructions are delivered in order. Each delivered `out_pc` is one greater than the previous one, starting at `RESET_PC`, and `out_instr` equals the memory word read at `out_pc`. While `out_valid` is 1 and `out_ready` is 0, the presented instruction stays unchanged.
- R3: When the sequential queue holds `DEPTH` entries (default 4) and no branch is pending, `mem_req` is 0.
- R4: Accepting a branch (`br_valid` and `br_ready` both 1) makes `br_ready` 0 until that branch resolves. A branch offered while `br_ready` is 0 is not accepted.
- R5: Target reads are issued only while the sequential queue is full. They read the target address first and then consecutive addresses, and they stop once the target queue holds `DEPTH` entries.
- R6: On a not-taken resolution, the queued sequential instructions remain valid. `out_valid` stays 1 in the next cycle if the sequential queue was non-empty, and the stream continues sequentially.
- R7: On a taken resolution, the next instruction delivered has `out_pc` equal to the branch target, and the following ones continue from target+1. No instruction is skipped or delivered twice. An instruction delivered in the resolution cycle itself belongs to the old path.
- R8: After a taken resolution, target words that were already prefetched are not read again. The first memory read is at target plus the number of target words prefetched.
- R9: A resolution pulse (`rs_valid`=1) while no branch is pending has no effect. `br_ready` stays 1 and the delivered stream is unchanged.
- R10: A sequential request that is not granted stays asserted with the same address in the next cycle, unless a resolution arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Word address of the request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid in a granted cycle |
| br_valid | input | 1 | Decode reports a conditional branch |
| br_target | input | AW | Word address of the branch target |
| br_ready | output | 1 | A branch can be accepted (none pending) |
| rs_valid | input | 1 | Execute reports the branch outcome |
| rs_taken | input | 1 | Outcome: 1 taken, 0 not taken |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Decoder accepts the presented instruction |
| out_instr | output | DW | Presented instruction word |
| out_pc | output | AW | Word address of the presented instruction |

## Verification
The bench fills both queues with the decoder stalled, then resolves taken. It checks that the target reads ran at ascending addresses, and that the first read afterwards skips past the words already held. A design that re-reads the target, or loses a queued target word in the swap, fails there. A not-taken resolution is checked for a bubble on `out_valid`: a design that flushed the wrong queue would drop the sequential instructions. Stray resolutions with nothing pending, resolutions landing in the same cycle as a delivery, and a withheld memory grant are mixed in by random stimulus. A reference stream model flags any skipped, duplicated or corrupted instruction.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

   typedef enum logic {
      SRC_SEQ = 1'b0,
      SRC_TGT = 1'b1
   } fetch_src_e;

endpackage

// File: rtl/dpp_fifo.sv
module dpp_fifo #(
   parameter int WIDTH = 48,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = store[rd_ptr];

   // pointer wrap: free-running for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= din;
   end

endmodule

// File: rtl/dpp_arbiter.sv
module dpp_arbiter
   import dpp_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          prim_full,
   input  logic          sec_full,
   input  logic          pending,
   input  logic [AW-1:0] seq_pc,
   input  logic [AW-1:0] tgt_pc,
   output logic          req,
   output logic [AW-1:0] addr,
   output fetch_src_e    src
);
   logic want_seq, want_tgt;

   assign want_seq = !prim_full;
   assign want_tgt = pending && !sec_full;

   always_comb begin
      req  = want_seq || want_tgt;
      src  = want_seq ? SRC_SEQ : SRC_TGT;
      addr = want_seq ? seq_pc : tgt_pc;
   end

endmodule

// File: rtl/dpp_branch_track.sv
module dpp_branch_track
   import dpp_pkg::*;
#(
   parameter int          AW       = 16,
   parameter logic [15:0] RESET_PC = 16'h0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          br_acc,
   input  logic [AW-1:0] br_target,
   input  logic          grant,
   input  fetch_src_e    src,
   input  logic          resolve,
   input  logic          taken,
   output logic          pending,
   output logic          sel,
   output logic [AW-1:0] seq_pc,
   output logic [AW-1:0] tgt_pc
);
   logic tgt_adv, seq_adv;

   assign tgt_adv = grant && (src == SRC_TGT);
   assign seq_adv = grant && (src == SRC_SEQ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         sel     <= 1'b0;
         seq_pc  <= AW'(RESET_PC);
         tgt_pc  <= '0;
      end else begin
         if (br_acc) begin
            pending <= 1'b1;
            tgt_pc  <= br_target;
         end else if (tgt_adv) begin
            tgt_pc  <= tgt_pc + 1'b1;
         end
         if (resolve) pending <= 1'b0;
         if (taken) begin
            sel    <= ~sel;
            seq_pc <= tgt_pc + AW'(tgt_adv);
         end else if (seq_adv) begin
            seq_pc <= seq_pc + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dual_path_prefetch.sv
module dual_path_prefetch
   import dpp_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          DW       = 32,
   parameter int          DEPTH    = 4,
   parameter logic [15:0] RESET_PC = 16'h0100
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   input  logic          br_valid,
   input  logic [AW-1:0] br_target,
   output logic          br_ready,
   input  logic          rs_valid,
   input  logic          rs_taken,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_instr,
   output logic [AW-1:0] out_pc
);
   localparam int EW = AW + DW;

   generate
      if (DEPTH < 2)  begin : g_bad_depth  $error("DEPTH must be at least 2"); end
      if (AW < 4 || AW > 16) begin : g_bad_aw $error("AW must be 4..16"); end
      if (DW < 1)     begin : g_bad_dw     $error("DW must be positive"); end
   endgenerate

   logic          pending, sel, grant, resolve, taken, not_taken, br_acc;
   logic          prim_full, sec_full, src_is_tgt;
   logic [AW-1:0] seq_pc, tgt_pc;
   fetch_src_e    src;

   logic [1:0]    buf_full, buf_empty, buf_push, buf_pop, buf_flush;
   logic [EW-1:0] buf_dout [2];

   assign grant      = mem_req && mem_gnt;
   assign resolve    = rs_valid && pending;
   assign taken      = resolve && rs_taken;
   assign not_taken  = resolve && !rs_taken;
   assign br_ready   = !pending;
   assign br_acc     = br_valid && br_ready;
   assign src_is_tgt = (src == SRC_TGT);
   assign prim_full  = buf_full[sel];
   assign sec_full   = buf_full[~sel];

   dpp_arbiter #(.AW(AW)) u_arb (
      .prim_full (prim_full),
      .sec_full  (sec_full),
      .pending   (pending),
      .seq_pc    (seq_pc),
      .tgt_pc    (tgt_pc),
      .req       (mem_req),
      .addr      (mem_addr),
      .src       (src)
   );

   dpp_branch_track #(.AW(AW), .RESET_PC(RESET_PC)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_acc    (br_acc),
      .br_target (br_target),
      .grant     (grant),
      .src       (src),
      .resolve   (resolve),
      .taken     (taken),
      .pending   (pending),
      .sel       (sel),
      .seq_pc    (seq_pc),
      .tgt_pc    (tgt_pc)
   );

   // two physical queues; sel names the one currently feeding decode
   generate
      for (genvar i = 0; i < 2; i++) begin : g_buf
         logic is_prim;
         assign is_prim      = (sel == 1'(i));
         assign buf_push[i]  = grant && (is_prim ? !src_is_tgt : src_is_tgt);
         assign buf_flush[i] = is_prim ? taken : not_taken;
         assign buf_pop[i]   = is_prim && out_valid && out_ready;

         dpp_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (buf_flush[i]),
            .push  (buf_push[i]),
            .din   ({mem_addr, mem_rdata}),
            .pop   (buf_pop[i]),
            .dout  (buf_dout[i]),
            .full  (buf_full[i]),
            .empty (buf_empty[i])
         );
      end
   endgenerate

   assign out_valid = !buf_empty[sel];
   assign {out_pc, out_instr} = buf_dout[sel];

endmodule

// File: rtl/dpp_checker.sv
module dpp_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic [AW-1:0] mem_addr,
   input logic          br_valid,
   input logic          br_ready,
   input logic          rs_valid,
   input logic          rs_taken,
   input logic          out_valid,
   input logic          out_ready,
   input logic [AW-1:0] out_pc,
   input logic          pending,
   input logic          prim_full,
   input logic          fetch_tgt
);

   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && !fetch_tgt && !rs_valid |=> mem_req && $stable(mem_addr));

   a_r5_tgt_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && fetch_tgt |-> prim_full && pending);

   a_r4_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_ready |=> !br_ready);

   a_r3_stop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      prim_full && !pending |-> !mem_req);

   a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !(rs_valid && rs_taken && pending)
      |=> out_valid && $stable(out_pc));

   a_r9_stray_resolve: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && !pending && !br_valid |=> br_ready);

endmodule

bind dual_path_prefetch dpp_checker #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_addr  (mem_addr),
   .br_valid  (br_valid),
   .br_ready  (br_ready),
   .rs_valid  (rs_valid),
   .rs_taken  (rs_taken),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_pc    (out_pc),
   .pending   (pending),
   .prim_full (prim_full),
   .fetch_tgt (src_is_tgt)
);

// File: tb/dual_path_prefetch_tb.sv
module dual_path_prefetch_tb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam logic [15:0] RST_PC = 16'h0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_req, mem_gnt = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic          br_valid = 1'b0, br_ready;
   logic [AW-1:0] br_target = '0;
   logic          rs_valid = 1'b0, rs_taken = 1'b0;
   logic          out_valid, out_ready = 1'b0;
   logic [DW-1:0] out_instr;
   logic [AW-1:0] out_pc;

   int n_chk = 0, n_bad = 0;

   // bench reference state
   logic [AW-1:0] exp_pc;
   logic          m_pend = 1'b0;
   logic [AW-1:0] m_tgt;
   logic          after_taken = 1'b0;
   logic          g_seen = 1'b0;
   logic [AW-1:0] g_addr;
   logic          hold_chk = 1'b0;
   logic [AW-1:0] hold_addr;

   always #5 clk = ~clk;

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return {a, ~a} ^ 32'hC3A5_0F1E;
   endfunction

   always_comb mem_rdata = mem_word(mem_addr);

   dual_path_prefetch #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .RESET_PC(RST_PC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .br_valid(br_valid), .br_target(br_target), .br_ready(br_ready),
      .rs_valid(rs_valid), .rs_taken(rs_taken),
      .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr), .out_pc(out_pc)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one cycle: inputs already set at a negedge; sample just before the posedge
   task automatic tick();
      #4;
      if (hold_chk) begin
         check("R10 req held", {63'd0, mem_req}, 64'd1);
         check("R10 addr held", 64'(mem_addr), 64'(hold_addr));
      end
      hold_chk  = mem_req && !mem_gnt && !m_pend && !rs_valid;
      hold_addr = mem_addr;
      if (mem_req && mem_gnt) begin
         g_seen = 1'b1;
         g_addr = mem_addr;
      end
      if (out_valid && out_ready) begin
         check(after_taken ? "R7 pc" : "R2 pc", 64'(out_pc), 64'(exp_pc));
         check(after_taken ? "R7 data" : "R2 data", 64'(out_instr), 64'(mem_word(exp_pc)));
         exp_pc = out_pc + 1'b1;
         after_taken = 1'b0;
      end
      if (br_valid)
         check("R4 br_ready", {63'd0, br_ready}, {63'd0, !m_pend});
      if (rs_valid && m_pend) begin
         if (rs_taken) begin
            exp_pc = m_tgt;
            after_taken = 1'b1;
         end
         m_pend = 1'b0;
      end else if (br_valid && br_ready) begin
         m_pend = 1'b1;
         m_tgt  = br_target;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      exp_pc = RST_PC;
      repeat (3) @(negedge clk);
      // R1: reset state, sampled while reset is held
      check("R1 out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 br_ready", {63'd0, br_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 req", {63'd0, mem_req}, 64'd1);
      check("R1 addr", 64'(mem_addr), 64'(RST_PC));

      // R3: fill with decoder stalled, fetching must stop
      mem_gnt = 1'b1;
      repeat (8) tick();
      check("R3 req stops", {63'd0, mem_req}, 64'd0);
      check("R3 head", 64'(out_pc), 64'(RST_PC));

      // R5: target prefetch into the second queue
      br_valid = 1'b1; br_target = 16'h0800;
      tick();
      br_valid = 1'b0;
      check("R4 pending", {63'd0, br_ready}, 64'd0);
      for (int k = 0; k < DEPTH; k++) begin
         g_seen = 1'b0;
         tick();
         check("R5 tgt grant", {63'd0, g_seen}, 64'd1);
         check("R5 tgt addr", 64'(g_addr), 64'(16'h0800 + k));
      end
      tick();
      check("R5 stop full", {63'd0, mem_req}, 64'd0);
      // second branch while pending is stalled
      br_valid = 1'b1; br_target = 16'h0C00;
      tick();
      br_valid = 1'b0;
      check("R4 stall", {63'd0, br_ready}, 64'd0);

      // R7/R8: taken, switch to prefetched target
      rs_valid = 1'b1; rs_taken = 1'b1;
      tick();
      rs_valid = 1'b0; rs_taken = 1'b0;
      check("R7 head", 64'(out_pc), 64'h0800);
      out_ready = 1'b1;
      g_seen = 1'b0;
      for (int k = 0; k < 10 && !g_seen; k++) tick();
      check("R8 first read", 64'(g_addr), 64'h0804);
      repeat (6) tick();

      // R6: not taken keeps the sequential queue, no bubble
      out_ready = 1'b0;
      repeat (8) tick();
      br_valid = 1'b1; br_target = 16'h0A00;
      tick();
      br_valid = 1'b0;
      repeat (6) tick();
      rs_valid = 1'b1; rs_taken = 1'b0; out_ready = 1'b1;
      tick();
      rs_valid = 1'b0;
      check("R6 no bubble", {63'd0, out_valid}, 64'd1);
      tick();
      check("R6 no bubble", {63'd0, out_valid}, 64'd1);
      repeat (6) tick();

      // R9: stray resolution with nothing pending
      rs_valid = 1'b1; rs_taken = 1'b1;
      tick();
      rs_valid = 1'b0; rs_taken = 1'b0;
      check("R9 br_ready", {63'd0, br_ready}, 64'd1);
      repeat (6) tick();
      check("R9 stream", 64'(out_pc), 64'(exp_pc));

      // R10: withheld grant
      mem_gnt = 1'b0; out_ready = 1'b1;
      repeat (4) tick();
      mem_gnt = 1'b1;

      // constrained random mix
      for (int c = 0; c < 4000; c++) begin
         mem_gnt   = ($urandom % 4) != 0;
         out_ready = ($urandom % 3) != 0;
         br_valid  = ($urandom % 7) == 0;
         br_target = AW'($urandom % 16'h4000);
         rs_valid  = ($urandom % 6) == 0;
         rs_taken  = $urandom % 2;
         tick();
      end
      br_valid = 1'b0; rs_valid = 1'b0;
      repeat (4) tick();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule